// File: doc/BRIEF.md
# Erase-Block Write-Protect Lock Controller

This block holds a protection state for each erase block of a flash array and applies range commands to those states. Each block is in one of three states: unlocked, locked, or lock-tight. A lock-tight block cannot be changed by any command. Only a cold reset returns it to locked.

Software-facing logic loads a first-block and a last-block register, then issues a command code with a one-cycle start strobe. The controller walks the selected blocks at one block per clock. It reports the state it last wrote, flags bad commands and out-of-range block indices, and raises a one-cycle done pulse. An interrupt controller can use that pulse to set its summary bit. A read port exposes the state of any block.

Top module: `wp_lock_ctrl`

## Requirements
- R1: Block states are one-hot. Lock-tight is 3'b001, locked is 3'b010 and unlocked is 3'b100. The query port returns the state of block `query_idx_i`.
- R2: When `rst_ni` is low (cold reset), every block becomes locked. In the same reset, the status becomes 3'b010, both range registers become 0, and busy, done and error are low.
- R3: Writing the first-block register loads `addr_wdata_i[ADDR_W-1:0]` into both range registers. Writing the last-block register loads only the last-block register. Upper data bits are dropped, so the mask is NUM_BLOCKS-1 when NUM_BLOCKS is a power of two.
- R4: Code 8'h23 unlocks each block from first to last inclusive, and code 8'h2A locks each of them. If first is greater than last, no block is visited.
- R5: During an unlock or lock walk, a lock-tight block ends the walk. That block and every later block keep their states.
- R6: Code 8'h2C (lock-tight range) leaves unlocked blocks as they are and makes every other block in the range lock-tight.
- R7: Code 8'h27 unlocks from block 0 through block NUM_BLOCKS-1. It stops at the first lock-tight block.
- R8: The status output holds the state most recently written to any block, and changes only during a walk or a reset.
- R9: A walk index at or above NUM_BLOCKS sets the error flag and ends the walk. An unknown command code also sets the error flag. The flag clears when the next command is accepted.
- R10: Busy rises in the cycle after an accepted start and lasts one cycle per visited block plus one final cycle. Done pulses for exactly that final cycle.
- R11: A start strobe received while busy is ignored.
- R12: A one-cycle `warm_rst_i` ends any walk. It sets the status to 3'b010, clears both range registers and the error flag, and leaves every block state unchanged.
- R13: A lock-tight block stays lock-tight through every command and through a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset strobe |
| start_we_i | input | 1 | Write strobe for the first-block register (also copies into last) |
| end_we_i | input | 1 | Write strobe for the last-block register |
| addr_wdata_i | input | 16 | Write data for the range registers |
| cmd_i | input | 8 | Command code, sampled on an accepted start |
| cmd_start_i | input | 1 | Command start strobe |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle pulse in the last busy cycle |
| cmd_err_o | output | 1 | Command error flag |
| wp_status_o | output | 3 | Last state written to a block |
| start_addr_o | output | ADDR_W | First-block register |
| end_addr_o | output | ADDR_W | Last-block register |
| query_idx_i | input | ADDR_W | Block index for state query |
| query_state_o | output | 3 | State of the queried block (3'b000 if out of range) |

## Verification
A corrupted block state is visible on the query port in the same cycle it is written. A wrong walk bound or a missed halt shows up as a neighbour block outside the expected span that changes or fails to change. It also shows as a busy length that differs from visited blocks plus one. A bad status or error update is visible on the ports in the cycle after the walk ends. That is the moment done drops and the bench samples.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  localparam logic [2:0] LK_TIGHT    = 3'b001;
  localparam logic [2:0] LK_LOCKED   = 3'b010;
  localparam logic [2:0] LK_UNLOCKED = 3'b100;

  localparam logic [7:0] CMD_UNLOCK     = 8'h23;
  localparam logic [7:0] CMD_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] CMD_LOCK       = 8'h2A;
  localparam logic [7:0] CMD_TIGHT      = 8'h2C;

  typedef enum logic [1:0] {OP_UNLOCK, OP_LOCK, OP_TIGHT} walk_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FIN} walk_st_e;
endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              start_we_i,
  input  logic              end_we_i,
  input  logic [15:0]       wdata_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o
);
  logic [ADDR_W-1:0] start_q, end_q, wval;
  assign wval = wdata_i[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (warm_rst_i) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (start_we_i) begin
        start_q <= wval;
        end_q   <= wval;
      end
      if (end_we_i) end_q <= wval;
    end
  end

  assign start_o = start_q;
  assign end_o   = end_q;

  // R3: first-block write mirrors into last-block
  a_r3_start_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_we_i && !end_we_i && !warm_rst_i) |=> (end_q == start_q));
endmodule

// File: rtl/wp_state_array.sv
module wp_state_array
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 24,
  parameter int ADDR_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_idx_i,
  input  logic [2:0]        wr_val_i,
  input  logic [ADDR_W-1:0] rd_a_idx_i,
  output logic [2:0]        rd_a_o,
  input  logic [ADDR_W-1:0] rd_b_idx_i,
  output logic [2:0]        rd_b_o
);
  logic [2:0] blk_q [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   blk_q[g] <= LK_LOCKED;
      else if (wr_en_i && wr_idx_i == ADDR_W'(g))    blk_q[g] <= wr_val_i;
    end

    a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(blk_q[g]));
    // R13: lock-tight is permanent until cold reset
    a_r13_tight_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk_q[g] == LK_TIGHT) |=> (blk_q[g] == LK_TIGHT));
  end

  always_comb begin
    rd_a_o = 3'b000;
    rd_b_o = 3'b000;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (rd_a_idx_i == ADDR_W'(i)) rd_a_o = blk_q[i];
      if (rd_b_idx_i == ADDR_W'(i)) rd_b_o = blk_q[i];
    end
  end
endmodule

// File: rtl/wp_walk_seq.sv
module wp_walk_seq
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 24,
  parameter int ADDR_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [7:0]        cmd_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] range_start_i,
  input  logic [ADDR_W-1:0] range_end_i,
  input  logic [2:0]        cur_state_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic              wr_en_o,
  output logic [2:0]        wr_val_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        wp_status_o
);
  localparam logic [ADDR_W:0]   NUM_EXT  = (ADDR_W+1)'(NUM_BLOCKS);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_BLOCKS - 1);

  walk_st_e          st_q;
  walk_op_e          op_q, op_dec;
  logic [ADDR_W-1:0] idx_q, end_q;
  logic              err_q;
  logic [2:0]        status_q;
  logic              is_range, is_all, oob, halt, skip, last;

  always_comb begin
    is_range = 1'b1;
    is_all   = 1'b0;
    op_dec   = OP_UNLOCK;
    unique case (cmd_i)
      CMD_UNLOCK:     op_dec = OP_UNLOCK;
      CMD_LOCK:       op_dec = OP_LOCK;
      CMD_TIGHT:      op_dec = OP_TIGHT;
      CMD_UNLOCK_ALL: begin is_range = 1'b0; is_all = 1'b1; end
      default:        is_range = 1'b0;
    endcase
  end

  assign oob  = {1'b0, idx_q} >= NUM_EXT;
  assign halt = (op_q != OP_TIGHT) && (cur_state_i == LK_TIGHT);
  assign skip = (op_q == OP_TIGHT) && (cur_state_i == LK_UNLOCKED);
  assign last = oob || halt || (idx_q == end_q);

  always_comb begin
    unique case (op_q)
      OP_LOCK:  wr_val_o = LK_LOCKED;
      OP_TIGHT: wr_val_o = LK_TIGHT;
      default:  wr_val_o = LK_UNLOCKED;
    endcase
  end
  assign wr_en_o = (st_q == ST_WALK) && !oob && !halt && !skip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_UNLOCK;
      idx_q    <= '0;
      end_q    <= '0;
      err_q    <= 1'b0;
      status_q <= LK_LOCKED;
    end else if (warm_rst_i) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_UNLOCK;
      idx_q    <= '0;
      end_q    <= '0;
      err_q    <= 1'b0;
      status_q <= LK_LOCKED;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          err_q <= 1'b0;
          op_q  <= op_dec;
          if (is_all) begin
            idx_q <= '0;
            end_q <= LAST_IDX;
            st_q  <= ST_WALK;
          end else if (is_range) begin
            idx_q <= range_start_i;
            end_q <= range_end_i;
            st_q  <= (range_start_i > range_end_i) ? ST_FIN : ST_WALK;
          end else begin
            err_q <= 1'b1;
            st_q  <= ST_FIN;
          end
        end
        ST_WALK: begin
          if (wr_en_o) status_q <= wr_val_o;
          if (oob)     err_q    <= 1'b1;
          if (last)    st_q     <= ST_FIN;
          else         idx_q    <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign err_o       = err_q;
  assign wp_status_o = status_q;

  // R10: done is the last busy cycle
  a_r10_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R8: status moves only from a walk or a warm reset
  a_r8_status_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q != $past(status_q)) |-> ($past(st_q == ST_WALK) || $past(warm_rst_i)));
  // R9: error is raised only by an active command
  a_r9_err_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> busy_o);
  // R11: a start while busy does not restart the sequence
  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WALK && start_i && !warm_rst_i && !last) |=> (st_q == ST_WALK));
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 24,
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              start_we_i,
  input  logic              end_we_i,
  input  logic [15:0]       addr_wdata_i,
  input  logic [7:0]        cmd_i,
  input  logic              cmd_start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cmd_err_o,
  output logic [2:0]        wp_status_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [ADDR_W-1:0] end_addr_o,
  input  logic [ADDR_W-1:0] query_idx_i,
  output logic [2:0]        query_state_o
);
  logic [ADDR_W-1:0] walk_idx;
  logic [2:0]        walk_state, wr_val;
  logic              wr_en;

  wp_range_regs #(.ADDR_W(ADDR_W)) u_range (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .start_we_i (start_we_i),
    .end_we_i   (end_we_i),
    .wdata_i    (addr_wdata_i),
    .start_o    (start_addr_o),
    .end_o      (end_addr_o)
  );

  wp_walk_seq #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .warm_rst_i    (warm_rst_i),
    .cmd_i         (cmd_i),
    .start_i       (cmd_start_i),
    .range_start_i (start_addr_o),
    .range_end_i   (end_addr_o),
    .cur_state_i   (walk_state),
    .idx_o         (walk_idx),
    .wr_en_o       (wr_en),
    .wr_val_o      (wr_val),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (cmd_err_o),
    .wp_status_o   (wp_status_o)
  );

  wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (walk_idx),
    .wr_val_i   (wr_val),
    .rd_a_idx_i (walk_idx),
    .rd_a_o     (walk_state),
    .rd_b_idx_i (query_idx_i),
    .rd_b_o     (query_state_o)
  );

  // R4: writes only land inside the array
  a_r4_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (int'(walk_idx) < NUM_BLOCKS));
endmodule

// File: tb/wp_lock_ctrl_tb.sv
module wp_lock_ctrl_tb;
  localparam int NB = 24;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          warm = 1'b0;
  logic          s_we = 1'b0, e_we = 1'b0;
  logic [15:0]   wdata = '0;
  logic [7:0]    cmd = '0;
  logic          go = 1'b0;
  logic          busy, done, err;
  logic [2:0]    wps, qst;
  logic [AW-1:0] sa, ea;
  logic [AW-1:0] qidx = '0;

  int total = 0;
  int bad   = 0;
  int bcyc, dcnt;

  always #2 clk = ~clk;

  wp_lock_ctrl #(.NUM_BLOCKS(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm),
    .start_we_i(s_we), .end_we_i(e_we), .addr_wdata_i(wdata),
    .cmd_i(cmd), .cmd_start_i(go),
    .busy_o(busy), .done_o(done), .cmd_err_o(err), .wp_status_o(wps),
    .start_addr_o(sa), .end_addr_o(ea),
    .query_idx_i(qidx), .query_state_o(qst)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic blk_is(input string req, input int idx, input int exp);
    qidx = AW'(idx);
    #1;
    chk(req, int'(qst), exp);
  endtask

  task automatic wr_start(input int v);
    @(negedge clk); s_we = 1'b1; wdata = 16'(v);
    @(negedge clk); s_we = 1'b0;
  endtask

  task automatic wr_end(input int v);
    @(negedge clk); e_we = 1'b1; wdata = 16'(v);
    @(negedge clk); e_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] code);
    int guard;
    @(negedge clk); cmd = code; go = 1'b1;
    @(negedge clk); go = 1'b0;
    bcyc = 0; dcnt = 0; guard = 0;
    while (busy && guard < 1000) begin
      if (done) dcnt++;
      bcyc++; guard++;
      @(negedge clk);
    end
    if (guard >= 1000) chk("R10 walk timeout", 1, 0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NB; i++) blk_is("R2 cold reset locked", i, 2);
    chk("R2 status", int'(wps), 2);
    chk("R2 busy", int'(busy), 0);
    chk("R2 err", int'(err), 0);
    chk("R2 done", int'(done), 0);
    chk("R2 start", int'(sa), 0);
    chk("R2 end", int'(ea), 0);
  endtask

  task automatic t_range;
    wr_start(5);
    chk("R3 start", int'(sa), 5);
    chk("R3 end copy", int'(ea), 5);
    wr_end(9);
    chk("R3 start kept", int'(sa), 5);
    chk("R3 end", int'(ea), 9);
    wr_start(16'hFFE3);
    chk("R3 masked start", int'(sa), 3);
    chk("R3 masked end", int'(ea), 3);
  endtask

  task automatic t_unlock_range;
    wr_start(3); wr_end(6);
    run_cmd(8'h23);
    chk("R10 busy length", bcyc, 5);
    chk("R10 done pulses", dcnt, 1);
    blk_is("R4 below range", 2, 2);
    for (int i = 3; i <= 6; i++) blk_is("R4 R1 unlocked=100", i, 4);
    blk_is("R4 above range", 7, 2);
    chk("R8 status unlocked", int'(wps), 4);
    chk("R9 no err", int'(err), 0);
  endtask

  task automatic t_lock_tight;
    wr_start(2); wr_end(8);
    run_cmd(8'h2C);
    chk("R6 busy length", bcyc, 8);
    blk_is("R6 R1 tight=001", 2, 1);
    for (int i = 3; i <= 6; i++) blk_is("R6 unlocked skipped", i, 4);
    blk_is("R6 tight", 7, 1);
    blk_is("R6 tight", 8, 1);
    blk_is("R6 outside", 9, 2);
    chk("R8 status tight", int'(wps), 1);
  endtask

  task automatic t_halt;
    wr_start(0); wr_end(1);
    run_cmd(8'h23);
    blk_is("R4 unlock 0", 0, 4);
    wr_end(10);
    run_cmd(8'h2A);
    chk("R5 busy length", bcyc, 4);
    blk_is("R4 R1 locked=010", 0, 2);
    blk_is("R4 lock 1", 1, 2);
    blk_is("R5 R13 tight kept", 2, 1);
    blk_is("R5 after halt untouched", 3, 4);
    chk("R8 status locked", int'(wps), 2);
  endtask

  task automatic t_unlock_all;
    run_cmd(8'h27);
    chk("R7 busy length", bcyc, 4);
    blk_is("R7 block0", 0, 4);
    blk_is("R7 block1", 1, 4);
    blk_is("R7 R13 halt tight", 2, 1);
    blk_is("R7 beyond halt", 9, 2);
    chk("R7 status", int'(wps), 4);
  endtask

  task automatic t_error;
    wr_start(20); wr_end(28);
    run_cmd(8'h2C);
    chk("R9 busy length", bcyc, 6);
    chk("R9 oob err", int'(err), 1);
    blk_is("R9 last valid tight", 23, 1);
    blk_is("R9 first tight", 20, 1);
    blk_is("R9 before range", 19, 2);
    wr_start(10);
    run_cmd(8'h55);
    chk("R9 unknown busy", bcyc, 1);
    chk("R9 unknown err", int'(err), 1);
    blk_is("R9 unknown no change", 10, 2);
    wr_start(12); wr_end(11);
    run_cmd(8'h23);
    chk("R4 empty busy", bcyc, 1);
    chk("R9 err cleared", int'(err), 0);
    blk_is("R4 empty no change 11", 11, 2);
    blk_is("R4 empty no change 12", 12, 2);
  endtask

  task automatic t_busy_ignore;
    int guard;
    wr_start(9); wr_end(12);
    @(negedge clk); cmd = 8'h23; go = 1'b1;
    @(negedge clk); cmd = 8'h2C; go = 1'b1;
    bcyc = 1; dcnt = 0; guard = 0;
    @(negedge clk); go = 1'b0;
    while (busy && guard < 1000) begin
      if (done) dcnt++;
      bcyc++; guard++;
      @(negedge clk);
    end
    chk("R11 busy length", bcyc, 5);
    chk("R11 one done", dcnt, 1);
    for (int i = 9; i <= 12; i++) blk_is("R11 second start ignored", i, 4);
    chk("R11 idle after", int'(busy), 0);
  endtask

  task automatic t_warm;
    run_cmd(8'h99);
    chk("R9 err before warm", int'(err), 1);
    @(negedge clk); warm = 1'b1;
    @(negedge clk); warm = 1'b0;
    chk("R12 status", int'(wps), 2);
    chk("R12 err", int'(err), 0);
    chk("R12 start", int'(sa), 0);
    chk("R12 end", int'(ea), 0);
    chk("R12 busy", int'(busy), 0);
    blk_is("R12 unlocked kept", 3, 4);
    blk_is("R12 R13 tight kept", 2, 1);
    blk_is("R12 R13 tight kept", 20, 1);
    blk_is("R12 locked kept", 15, 2);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL R10 watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_range;
    t_unlock_range;
    t_lock_tight;
    t_halt;
    t_unlock_all;
    t_error;
    t_busy_ignore;
    t_warm;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule